// File: doc/BRIEF.md
# Program Memory Checksum Accumulator

This block folds a stream of 14-bit program words into a 16-bit checksum and then adds a term derived from the configuration word. A single-cycle start pulse arms it. Words are then presented on a valid/word pair, and valid may drop between words at any time. After exactly 1024 accepted words the block adds the configuration term and presents the result with a one-cycle done pulse.

Two modes are chosen by a protect-select input, which is captured at start. In plain mode each word is summed as it is. The configuration word is masked to its five low bits, and a fixed offset of 0x3FE0 is added. In protected mode each word is first reduced to a 7-bit value: bit by bit, the XNOR of its upper seven bits with its lower seven bits. The configuration term is then the masked word with bits 5 and 6 forced high, and no offset is added.

Top module: `cksum_accum`

## Requirements
- R1: After reset `sumDone` is 0 and `sumOut` is 0x0000.
- R2: In plain mode the result is the low 16 bits of (sum of all 1024 raw words) + (cfgWord AND 0x1F) + 0x3FE0.
- R3: In protected mode each word w contributes the 7-bit value NOT(w[13:7] XOR w[6:0]), zero-extended.
- R4: In protected mode the configuration term is (cfgWord AND 0x1F) OR 0x60, and no constant offset is added. The result is the low 16 bits of the sum.
- R5: A start pulse clears the accumulator and word count. A start during an unfinished run discards all words accepted so far.
- R6: `protectSel` is captured on the start cycle. Changing it during a run has no effect on the result.
- R7: `sumDone` is high for exactly one cycle, in the cycle after the clock edge that follows the edge accepting the 1024th word. `cfgWord` is sampled on that later edge. `sumOut` then holds its value until the next run completes.
- R8: Cycles with `wordValid` low between words do not change the sum.
- R9: Valid words presented before the first start or after a run completes are ignored. No done pulse follows, and `sumOut` is unchanged.
- R10: A valid word presented in the same cycle as a start pulse is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a new run; clears the accumulator and captures the mode |
| protectSel | input | 1 | 1 selects protected (scrambled) mode, captured at start |
| wordValid | input | 1 | Qualifies `wordIn` this cycle |
| wordIn | input | 14 | Program word |
| cfgWord | input | 14 | Configuration word, sampled at the finishing edge |
| sumDone | output | 1 | One-cycle pulse when `sumOut` carries a new result |
| sumOut | output | 16 | Checksum result, held between runs |

## Verification
A start pulse and a valid word can arrive in the same cycle, and the start must win. The bench pulses start while driving an all-ones word with valid high. It then streams 1024 zero words in plain mode. A result of 0x3FE0 shows the colliding word was dropped; 0x7FDF would show it leaked in. A start can also land in the middle of a run. This case is provoked by restarting after 300 all-ones words and is judged by whether the later result matches only the second stream.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

  // Strobes from the sequencer to the datapath, at most one high per cycle.
  typedef struct packed {
    logic clearAcc;   // start: zero the sum, capture the mode
    logic addWord;    // fold the current word into the sum
    logic finalize;   // add configuration term and publish
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FINAL = 2'd2
  } seqState_t;

endpackage

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import cksum_pkg::*;
#(
  parameter int NUM_WORDS = 1024
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         wordValid,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  seqState_t        state;
  logic [CNT_W-1:0] wordCount;

  // Start always wins over any other activity in its cycle.
  always_comb begin
    strobes.clearAcc = startPulse;
    strobes.addWord  = !startPulse && (state == ST_ACCUM) && wordValid;
    strobes.finalize = !startPulse && (state == ST_FINAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordCount <= '0;
    end else if (startPulse) begin
      state     <= ST_ACCUM;
      wordCount <= '0;
    end else begin
      unique case (state)
        ST_ACCUM: begin
          if (wordValid) begin
            if (wordCount == LAST_IDX) begin
              state <= ST_FINAL;
            end else begin
              wordCount <= wordCount + 1'b1;
            end
          end
        end
        ST_FINAL: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R7: the last accepted word is followed by finalize unless a start intervenes
  assert_final_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.addWord && wordCount == LAST_IDX) |=> (strobes.finalize || startPulse));

  // R9: once finalized, no word is taken until a new start
  assert_quiet_after_final_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finalize && !startPulse) |=> (!strobes.addWord && !strobes.finalize));

  // R10: a start cycle never also folds a word in
  assert_start_blocks_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !strobes.addWord);

endmodule

// File: rtl/cksum_dp.sv
module cksum_dp
  import cksum_pkg::*;
#(
  parameter int                WORD_W       = 14,
  parameter int                SUM_W        = 16,
  parameter logic [WORD_W-1:0] CFG_KEEP     = 14'h001F,
  parameter logic [WORD_W-1:0] PROT_CFG_SET = 14'h0060,
  parameter logic [SUM_W-1:0]  PLAIN_OFFSET = 16'h3FE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              protectSel,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [WORD_W-1:0] cfgWord,
  output logic              sumDone,
  output logic [SUM_W-1:0]  sumOut
);

  localparam int HALF_W = WORD_W / 2;

  logic              protLatched;
  logic [SUM_W-1:0]  accSum;
  logic [HALF_W-1:0] scrBits;
  logic [SUM_W-1:0]  wordTerm;
  logic [SUM_W-1:0]  cfgTerm;
  logic [WORD_W-1:0] cfgMasked;

  // Scrambled form: each low bit XNOR its partner in the upper half.
  for (genvar g = 0; g < HALF_W; g++) begin : g_scr
    assign scrBits[g] = ~(wordIn[g + HALF_W] ^ wordIn[g]);
  end

  always_comb begin
    cfgMasked = cfgWord & CFG_KEEP;
    if (protLatched) begin
      wordTerm = SUM_W'(scrBits);
      cfgTerm  = SUM_W'(cfgMasked | PROT_CFG_SET);
    end else begin
      wordTerm = SUM_W'(wordIn);
      cfgTerm  = SUM_W'(cfgMasked) + PLAIN_OFFSET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protLatched <= 1'b0;
      accSum      <= '0;
    end else if (strobes.clearAcc) begin
      protLatched <= protectSel;
      accSum      <= '0;
    end else if (strobes.addWord) begin
      accSum <= accSum + wordTerm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumDone <= 1'b0;
      sumOut  <= '0;
    end else begin
      sumDone <= strobes.finalize;
      if (strobes.finalize) begin
        sumOut <= accSum + cfgTerm;
      end
    end
  end

  // R7: done never lasts two cycles
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sumDone |=> !sumDone);

  // R5: start leaves an empty accumulator
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> (accSum == '0));

  // R8: no add, no clear -> sum untouched
  assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clearAcc && !strobes.addWord) |=> $stable(accSum));

  // R9: the published result only moves on finalize
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finalize |=> ($stable(sumOut) && !sumDone));

  // R6: the mode only changes at start
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAcc |=> $stable(protLatched));

endmodule

// File: rtl/cksum_accum.sv
module cksum_accum
  import cksum_pkg::*;
#(
  parameter int WORD_W    = 14,
  parameter int SUM_W     = 16,
  parameter int NUM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              protectSel,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [WORD_W-1:0] cfgWord,
  output logic              sumDone,
  output logic [SUM_W-1:0]  sumOut
);

  ctrlStrobes_t strobes;

  cksum_ctrl #(
    .NUM_WORDS(NUM_WORDS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .wordValid (wordValid),
    .strobes   (strobes)
  );

  cksum_dp #(
    .WORD_W(WORD_W),
    .SUM_W (SUM_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .protectSel(protectSel),
    .wordIn    (wordIn),
    .cfgWord   (cfgWord),
    .sumDone   (sumDone),
    .sumOut    (sumOut)
  );

endmodule

// File: tb/cksum_accum_tb_top.sv
`timescale 1ns/1ps
module cksum_accum_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        protectSel = 1'b0;
  logic        wordValid = 1'b0;
  logic [13:0] wordIn = '0;
  logic [13:0] cfgWord = '0;
  logic        sumDone;
  logic [15:0] sumOut;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cksum_accum dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .protectSel(protectSel),
    .wordValid(wordValid), .wordIn(wordIn), .cfgWord(cfgWord),
    .sumDone(sumDone), .sumOut(sumOut)
  );

  function automatic logic [13:0] genWord(int seed, int i);
    int v;
    v = (i * 37 + seed * 101) ^ (i * i * 3);
    return 14'(v);
  endfunction

  function automatic int scr7(logic [13:0] w);
    logic [6:0] s;
    s = ~(w[13:7] ^ w[6:0]);
    return int'(s);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(bit prot, bit withWord, logic [13:0] w);
    @(negedge clk);
    startPulse = 1'b1;
    protectSel = prot;
    wordValid  = withWord;
    wordIn     = w;
    @(negedge clk);
    startPulse = 1'b0;
    wordValid  = 1'b0;
  endtask

  // Streams 1024 words (seed < 0 gives all zeros); returns raw and scrambled sums.
  task automatic feedWords(int seed, int gapEvery, bit toggleMode,
                           output int sumRaw, output int sumScr, output bit earlyDone);
    logic [13:0] w;
    sumRaw = 0; sumScr = 0; earlyDone = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) begin
        wordValid = 1'b0;
        wordIn    = 14'h2AAA;
        @(negedge clk);
        if (sumDone) earlyDone = 1'b1;
      end
      w = (seed < 0) ? 14'h0000 : genWord(seed, i);
      wordValid = 1'b1;
      wordIn    = w;
      sumRaw += int'(w);
      sumScr += scr7(w);
      if (toggleMode && i == 500) protectSel = ~protectSel;
      @(negedge clk);
      if (sumDone) earlyDone = 1'b1;
    end
    wordValid = 1'b0;
  endtask

  // Called right after the edge that took the last word.
  task automatic finishCheck(string req, int exp);
    check("R7", {req, " done not before finishing edge"}, int'(sumDone), 0);
    @(negedge clk);
    check("R7", {req, " done pulse"}, int'(sumDone), 1);
    check(req, "checksum value", int'(sumOut), exp);
    @(negedge clk);
    check("R7", {req, " done drops after one cycle"}, int'(sumDone), 0);
    check("R7", {req, " result held"}, int'(sumOut), exp);
  endtask

  function automatic int plainExp(int raw, logic [13:0] cfg);
    return (raw + int'(cfg & 14'h1F) + 'h3FE0) & 'hFFFF;
  endfunction

  function automatic int protExp(int scr, logic [13:0] cfg);
    return (scr + int'((cfg & 14'h1F) | 14'h60)) & 'hFFFF;
  endfunction

  task automatic testReset();
    check("R1", "reset done", int'(sumDone), 0);
    check("R1", "reset sum", int'(sumOut), 0);
  endtask

  task automatic testBeforeStart();
    bit sawDone = 1'b0;
    for (int i = 0; i < 30; i++) begin
      wordValid = 1'b1; wordIn = 14'h3FFF;
      @(negedge clk);
      if (sumDone) sawDone = 1'b1;
    end
    wordValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "no done before start", int'(sawDone), 0);
    check("R9", "sum untouched before start", int'(sumOut), 0);
  endtask

  task automatic testPlainOnes();
    int r, s; bit e;
    cfgWord = 14'h3FFF;
    pulseStart(1'b0, 1'b0, '0);
    for (int i = 0; i < 1024; i++) begin
      wordValid = 1'b1; wordIn = 14'h3FFF; @(negedge clk);
    end
    wordValid = 1'b0;
    r = 1024 * 'h3FFF; s = 0; e = 1'b0;
    finishCheck("R2", plainExp(r, cfgWord));
    check("R2", "all-ones plain known value", int'(sumOut), 'h3BFF);
    if (s != 0 || e) check("R2", "internal", 1, 0);
  endtask

  task automatic testProtOnes();
    cfgWord = 14'h3FEF;
    pulseStart(1'b1, 1'b0, '0);
    for (int i = 0; i < 1024; i++) begin
      wordValid = 1'b1; wordIn = 14'h3FFF; @(negedge clk);
    end
    wordValid = 1'b0;
    finishCheck("R4", protExp(1024 * 'h7F, cfgWord));
    check("R4", "all-ones protected known value", int'(sumOut), 'hFC6F);
  endtask

  task automatic testPatternPlain();
    int r, s; bit e;
    cfgWord = 14'h1A35;
    pulseStart(1'b0, 1'b0, '0);
    feedWords(7, 0, 1'b0, r, s, e);
    check("R7", "no early done plain pattern", int'(e), 0);
    finishCheck("R2", plainExp(r, cfgWord));
  endtask

  task automatic testPatternProtGaps();
    int r, s; bit e;
    cfgWord = 14'h0ACE;
    pulseStart(1'b1, 1'b0, '0);
    feedWords(19, 5, 1'b0, r, s, e);
    check("R8", "no early done with gaps", int'(e), 0);
    finishCheck("R3", protExp(s, cfgWord));
  endtask

  task automatic testPlainGaps();
    int r, s; bit e;
    cfgWord = 14'h0013;
    pulseStart(1'b0, 1'b0, '0);
    feedWords(3, 3, 1'b0, r, s, e);
    finishCheck("R8", plainExp(r, cfgWord));
  endtask

  task automatic testModeLatched();
    int r, s; bit e;
    cfgWord = 14'h2222;
    pulseStart(1'b1, 1'b0, '0);
    feedWords(11, 0, 1'b1, r, s, e);
    finishCheck("R6", protExp(s, cfgWord));
    protectSel = 1'b0;
  endtask

  task automatic testRestart();
    int r, s; bit e;
    cfgWord = 14'h0005;
    pulseStart(1'b0, 1'b0, '0);
    for (int i = 0; i < 300; i++) begin
      wordValid = 1'b1; wordIn = 14'h3FFF; @(negedge clk);
    end
    wordValid = 1'b0;
    pulseStart(1'b0, 1'b0, '0);
    feedWords(23, 0, 1'b0, r, s, e);
    finishCheck("R5", plainExp(r, cfgWord));
  endtask

  task automatic testStartCollision();
    int r, s; bit e;
    cfgWord = 14'h0000;
    pulseStart(1'b0, 1'b1, 14'h3FFF);
    feedWords(-1, 0, 1'b0, r, s, e);
    finishCheck("R10", 'h3FE0);
  endtask

  task automatic testAfterDone();
    int last;
    bit sawDone = 1'b0;
    last = int'(sumOut);
    for (int i = 0; i < 40; i++) begin
      wordValid = 1'b1; wordIn = genWord(5, i);
      @(negedge clk);
      if (sumDone) sawDone = 1'b1;
    end
    wordValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "no done after finished run", int'(sawDone), 0);
    check("R9", "sum held after finished run", int'(sumOut), last);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBeforeStart();
    testPlainOnes();
    testProtOnes();
    testPatternPlain();
    testPatternProtGaps();
    testPlainGaps();
    testModeLatched();
    testRestart();
    testStartCollision();
    testAfterDone();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule